// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned operands and reports whether the first is below, equal to or above the second. It is built from 4-bit slices. Each slice has three relation inputs for the result from below and three relation outputs of the same kind. A slice uses its incoming relation only when its own operand nibbles match. Otherwise its own nibbles decide the result. Slices therefore chain from the least significant nibble upward, and the most significant differing nibble settles the answer.

The top module chains three slices into a 12-bit comparator. The incoming relation of the lowest slice is brought out to ports. A standalone compare ties those ports to below=0, equal=1, above=0. A wider compare feeds them from another comparator that handles less significant bits.

The block is purely combinational, with no clock and no reset. It passes values straight through, so it has no valid/ready interface and no back-pressure. The outputs follow the inputs in the same cycle.

Top module: `mag_cmp_chain`

## Requirements
- R1: When `a_i` > `b_i` as unsigned numbers, `gt_o`=1, `eq_o`=0 and `lt_o`=0, whatever the relation inputs are.
- R2: When `a_i` < `b_i` as unsigned numbers, `lt_o`=1, `eq_o`=0 and `gt_o`=0, whatever the relation inputs are.
- R3: When `a_i` == `b_i`, `eq_o` equals `rel_eq_i`.
- R4: When `a_i` == `b_i`, `gt_o` equals `rel_gt_i` and `lt_o` equals `rel_lt_i`. This holds for all eight settings of the relation inputs, including settings that are not valid.
- R5: The most significant differing nibble decides the result. The opposite relation in any lower nibble has no effect on the outputs.
- R6: When exactly one relation input is 1, exactly one of `lt_o`, `eq_o` and `gt_o` is 1.
- R7: Inside a slice the upper bit decides first. For a 2-bit pair, `a` is above `b` when a1>b1, or when a1==b1 and a0>b0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 12 | First unsigned operand |
| b_i | input | 12 | Second unsigned operand |
| rel_lt_i | input | 1 | Incoming relation from less significant bits: below |
| rel_eq_i | input | 1 | Incoming relation from less significant bits: equal |
| rel_gt_i | input | 1 | Incoming relation from less significant bits: above |
| lt_o | output | 1 | `a_i` below `b_i` |
| eq_o | output | 1 | `a_i` equal to `b_i` |
| gt_o | output | 1 | `a_i` above `b_i` |

## Verification
Two things can act in the same evaluation: the slice's own nibble decision and the relation passed in from below. They collide whenever the upper nibbles are equal while lower bits differ. The bench provokes this exhaustively. It holds the upper eight bits equal, sweeps every pair of low nibbles under all eight relation-input settings, and expects the incoming relation to win only on an exact nibble match. Random 12-bit pairs and directed cases then set one nibble against the opposite relation in a lower nibble. Each output is judged against results from native relational operators.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } rel_t;

  localparam rel_t REL_EQUAL = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};
endpackage

// File: rtl/mag_cmp_bit.sv
module mag_cmp_bit
  import mag_cmp_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  rel_t below_i,
  output rel_t rel_o
);
  logic same;
  assign same = ~(a_i ^ b_i);

  always_comb begin
    if (same) rel_o = below_i;
    else      rel_o = '{lt: b_i, eq: 1'b0, gt: a_i};
  end
endmodule

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  rel_t         casc_i,
  output rel_t         casc_o
);
  rel_t stage [W+1];
  assign stage[0] = casc_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    mag_cmp_bit u_bit (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .below_i(stage[i]),
      .rel_o  (stage[i+1])
    );
  end

  assign casc_o = stage[W];
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 3,
  localparam int WIDTH  = SLICE_W * SLICES
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             rel_lt_i,
  input  logic             rel_eq_i,
  input  logic             rel_gt_i,
  output logic             lt_o,
  output logic             eq_o,
  output logic             gt_o
);
  rel_t link [SLICES+1];
  assign link[0] = '{lt: rel_lt_i, eq: rel_eq_i, gt: rel_gt_i};

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    mag_cmp_slice #(.W(SLICE_W)) u_slice (
      .a_i   (a_i[s*SLICE_W +: SLICE_W]),
      .b_i   (b_i[s*SLICE_W +: SLICE_W]),
      .casc_i(link[s]),
      .casc_o(link[s+1])
    );
  end

  assign lt_o = link[SLICES].lt;
  assign eq_o = link[SLICES].eq;
  assign gt_o = link[SLICES].gt;
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
  parameter int WIDTH = 12
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             rel_lt_i,
  input logic             rel_eq_i,
  input logic             rel_gt_i,
  input logic             lt_o,
  input logic             eq_o,
  input logic             gt_o
);
  always_comb begin
    if (a_i > b_i)
      p_above_wins_r1: assert ({lt_o, eq_o, gt_o} == 3'b001);
    if (a_i < b_i)
      p_below_wins_r2: assert ({lt_o, eq_o, gt_o} == 3'b100);
    if (a_i == b_i) begin
      p_eq_passes_r3: assert (eq_o == rel_eq_i);
      p_sides_pass_r4: assert (gt_o == rel_gt_i && lt_o == rel_lt_i);
    end
    if ($countones({rel_lt_i, rel_eq_i, rel_gt_i}) == 1)
      p_single_out_r6: assert ($countones({lt_o, eq_o, gt_o}) == 1);
  end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i),
  .rel_lt_i(rel_lt_i), .rel_eq_i(rel_eq_i), .rel_gt_i(rel_gt_i),
  .lt_o(lt_o), .eq_o(eq_o), .gt_o(gt_o)
);

// File: tb/tb_mag_cmp_chain.sv
module tb_mag_cmp_chain;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [11:0] a, b;
  logic r_lt, r_eq, r_gt;
  logic lt, eq, gt;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  mag_cmp_chain dut (
    .a_i(a), .b_i(b), .rel_lt_i(r_lt), .rel_eq_i(r_eq), .rel_gt_i(r_gt),
    .lt_o(lt), .eq_o(eq), .gt_o(gt)
  );

  function automatic logic [2:0] expect_rel(logic [11:0] x, logic [11:0] y,
                                            logic [2:0] cas);
    if (x > y) return 3'b001;
    if (x < y) return 3'b100;
    return cas;
  endfunction

  task automatic drive_check(logic [11:0] x, logic [11:0] y, logic [2:0] cas,
                             string req);
    logic [2:0] exp;
    @(negedge clk);
    a = x; b = y; {r_lt, r_eq, r_gt} = cas;
    @(posedge clk); #1;
    exp = expect_rel(x, y, cas);
    n_chk++;
    if ({lt, eq, gt} !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h cas=%b got=%b expected=%b",
               req, x, y, cas, {lt, eq, gt}, exp);
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    a = '0; b = '0; {r_lt, r_eq, r_gt} = 3'b010;
    seed_dummy = $urandom(32'h1c0de5);
    // quiescent state: equal zero operands with neutral relation give equal (R3)
    drive_check(12'h000, 12'h000, 3'b010, "R3 idle");
    // directed corners
    drive_check(12'hfff, 12'h000, 3'b100, "R1 max>min");
    drive_check(12'h000, 12'hfff, 3'b001, "R2 min<max");
    drive_check(12'h800, 12'h7ff, 3'b010, "R5 top nibble beats lower");
    drive_check(12'h0f0, 12'h10f, 3'b010, "R5 upper nibble dominates");
    drive_check(12'h001, 12'h000, 3'b100, "R1 lsb");
    drive_check(12'h2a2, 12'h2a1, 3'b100, "R7 bit1 over bit0");
    drive_check(12'h2a1, 12'h2a2, 3'b001, "R7 bit1 under bit0");
    drive_check(12'habc, 12'habc, 3'b000, "R4 invalid cascade zero");
    drive_check(12'habc, 12'habc, 3'b111, "R4 invalid cascade all");
    // exhaustive low slice, upper bits equal, all cascade settings (R3 R4 R5 R6 R7)
    for (int c = 0; c < 8; c++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          logic [7:0] up;
          up = 8'($urandom);
          drive_check({up, 4'(x)}, {up, 4'(y)}, 3'(c), "R3_R4_R6 slice sweep");
        end
    // random 12-bit against native operators (R1 R2 R5 R6)
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] x, y;
      x = 12'($urandom);
      y = (k % 4 == 0) ? {x[11:4], 4'($urandom)} : 12'($urandom);
      drive_check(x, y, 3'b010, "R1_R2_R5 random");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=hang expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule